// File: doc/BRIEF.md
# LCD Controller Register and Interrupt Block

This block is the software-visible register bank of a simple framebuffer LCD controller. A 32-bit bus port reaches six word registers: a control register, three panel-timing registers, a read-only status register and a subpanel register. Each register keeps only its writable bits. Some registers return fixed ones on read-back. The timing and subpanel contents, together with the display-mode bits of the control register, leave the block as plain outputs for the timing generator and the pixel path. The block does not use them itself.

The block also owns the three sticky event flags: frame done, palette loaded and sync error. It combines them into one registered level interrupt. When software changes the enable bit, the block sends a one-cycle start or stop pulse to the fetch sequencer and updates the flags to match. The sequencer reports its events back as single-cycle pulses.

Top module: `lcdr_top`

## Requirements
- R1: After reset the block reads back only its constant bits: control 0xFE000C34, timing0 0x0000000F, timing1 0x00000000, timing2 0xFC000000, status 0, subpanel 0. `irq_o`, `fetch_start_o` and `fetch_stop_o` are low.
- R2: Control register (offset 0x00) fields: enable bit 0, mono bit 1, interrupt enables bits 4:3, colour-panel flag bit 7, palette mode bits 21:20. Other written bits are kept under mask 0x01CFF300. A read returns the stored bits ORed with 0xFE000C34, with the colour-panel flag also shown at bit 23.
- R3: Timing0 (0x04) and timing1 (0x08) keep a 10-bit count-minus-one in bits 9:0 and the upper 22 bits separately. Both read back as written, except that timing0 also ORs in 0x0000000F.
- R4: Timing2 (0x0C) keeps all 32 bits and reads back with 0xFC000000 ORed in.
- R5: Subpanel (0x14) keeps only the bits in mask 0xA1FFFFFF.
- R6: A write to status (0x10), to an offset above 0x14, or to an address with either of its two low bits set changes no register. Those unmapped addresses read as zero.
- R7: An event pulse sets its flag at the next clock edge, and the flag stays set. Status read: frame done bit 0, sync error bit 2, palette loaded bit 6.
- R8: `irq_o` follows the flags with one cycle of delay. It is high when frame done has enable bit 3 set, when palette loaded has enable bit 4 set, or whenever sync error is set. Otherwise it is low.
- R9: When a control write changes enable from 0 to 1, `fetch_start_o` goes high for exactly one cycle. At the end of that cycle the frame-done and palette-loaded flags clear.
- R10: When a control write changes enable from 1 to 0, `fetch_stop_o` goes high for exactly one cycle. At the end of that cycle sync error clears, and frame done sets unless the palette mode is 1.
- R11: A control write that leaves enable unchanged produces no pulse and leaves the flags alone.
- R12: The clearing done by a start or stop wins over an event pulse for the same flag in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address within the block |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational, zero when not reading |
| ev_frame_i | input | 1 | Frame-done pulse from the sequencer |
| ev_pal_i | input | 1 | Palette-loaded pulse from the sequencer |
| ev_sync_i | input | 1 | Sync-error pulse from the sequencer |
| fetch_start_o | output | 1 | One-cycle start pulse |
| fetch_stop_o | output | 1 | One-cycle stop pulse |
| irq_o | output | 1 | Level interrupt |
| mono_o | output | 1 | Monochrome mode |
| tft_o | output | 1 | Colour-panel flag |
| plm_o | output | 2 | Palette mode |
| pix_per_line_o | output | CNT_W | Pixels per line minus one |
| hor_ext_o | output | 32-CNT_W | Upper timing0 bits |
| lines_o | output | CNT_W | Lines per panel minus one |
| ver_ext_o | output | 32-CNT_W | Upper timing1 bits |
| tim2_o | output | 32 | Timing2 contents |
| subpanel_o | output | 32 | Subpanel contents |

## Verification
The hardest case to reach is an event pulse that arrives in the same cycle as a start or stop pulse. From the ports, this means raising the event line exactly during the cycle after the enable-changing write. The bench writes the control register and then raises the event line at once, before the next clock edge. This tests the priority in R12. Palette mode 1 is also only seen on a disable. So the bench enables the block, sets sync error and then disables with mode 1, to show that the stop still clears sync error without setting frame done.

// File: rtl/lcdr_pkg.sv
package lcdr_pkg;
    localparam logic [31:0] CTRL_KEEP_MASK = 32'h01CF_F300;
    localparam logic [31:0] CTRL_RD_ONES   = 32'hFE00_0C34;
    localparam logic [31:0] TIM0_RD_ONES   = 32'h0000_000F;
    localparam logic [31:0] TIM2_RD_ONES   = 32'hFC00_0000;
    localparam logic [31:0] SUBP_KEEP_MASK = 32'hA1FF_FFFF;

    localparam int IDX_CTRL = 0;
    localparam int IDX_TIM0 = 1;
    localparam int IDX_TIM1 = 2;
    localparam int IDX_TIM2 = 3;
    localparam int IDX_STAT = 4;
    localparam int IDX_SUBP = 5;

    typedef struct packed {
        logic        en;
        logic        mono;
        logic [1:0]  ie;
        logic        tft;
        logic [1:0]  plm;
        logic [31:0] rest;
    } ctrl_t;

    typedef struct packed {
        logic frame;
        logic pal;
        logic sync;
    } flags_t;
endpackage

// File: rtl/lcdr_regs.sv
module lcdr_regs
    import lcdr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 10
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                sel_i,
    input  logic                we_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [31:0]         wdata_i,
    input  flags_t              flags_i,
    output logic [31:0]         rdata_o,
    output ctrl_t               ctrl_o,
    output logic [CNT_W-1:0]    hcnt_o,
    output logic [31-CNT_W:0]   hext_o,
    output logic [CNT_W-1:0]    vcnt_o,
    output logic [31-CNT_W:0]   vext_o,
    output logic [31:0]         tim2_o,
    output logic [31:0]         subp_o
);
    localparam int IW = ADDR_W - 2;

    typedef struct packed {
        ctrl_t              ctrl;
        logic [CNT_W-1:0]   hcnt;
        logic [31-CNT_W:0]  hext;
        logic [CNT_W-1:0]   vcnt;
        logic [31-CNT_W:0]  vext;
        logic [31:0]        tim2;
        logic [31:0]        subp;
    } regs_t;

    regs_t r_d, r_q;
    logic [IW-1:0] idx;
    logic          aligned;

    assign idx     = addr_i[ADDR_W-1:2];
    assign aligned = (addr_i[1:0] == 2'b00);

    always_comb begin
        r_d = r_q;
        if (sel_i && we_i && aligned) begin
            case (idx)
                IW'(IDX_CTRL): begin
                    r_d.ctrl.en   = wdata_i[0];
                    r_d.ctrl.mono = wdata_i[1];
                    r_d.ctrl.ie   = wdata_i[4:3];
                    r_d.ctrl.tft  = wdata_i[7];
                    r_d.ctrl.plm  = wdata_i[21:20];
                    r_d.ctrl.rest = wdata_i & CTRL_KEEP_MASK;
                end
                IW'(IDX_TIM0): {r_d.hext, r_d.hcnt} = wdata_i;
                IW'(IDX_TIM1): {r_d.vext, r_d.vcnt} = wdata_i;
                IW'(IDX_TIM2): r_d.tim2 = wdata_i;
                IW'(IDX_SUBP): r_d.subp = wdata_i & SUBP_KEEP_MASK;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    always_comb begin
        rdata_o = '0;
        if (sel_i && !we_i && aligned) begin
            case (idx)
                IW'(IDX_CTRL): rdata_o = r_q.ctrl.rest | CTRL_RD_ONES
                                       | (32'(r_q.ctrl.tft) << 23)
                                       | (32'(r_q.ctrl.plm) << 20)
                                       | (32'(r_q.ctrl.tft) << 7)
                                       | (32'(r_q.ctrl.ie) << 3)
                                       | (32'(r_q.ctrl.mono) << 1)
                                       | 32'(r_q.ctrl.en);
                IW'(IDX_TIM0): rdata_o = {r_q.hext, r_q.hcnt} | TIM0_RD_ONES;
                IW'(IDX_TIM1): rdata_o = {r_q.vext, r_q.vcnt};
                IW'(IDX_TIM2): rdata_o = r_q.tim2 | TIM2_RD_ONES;
                IW'(IDX_STAT): rdata_o = 32'({flags_i.pal, 3'b000, flags_i.sync,
                                              1'b0, flags_i.frame});
                IW'(IDX_SUBP): rdata_o = r_q.subp;
                default:       rdata_o = '0;
            endcase
        end
    end

    assign ctrl_o = r_q.ctrl;
    assign hcnt_o = r_q.hcnt;
    assign hext_o = r_q.hext;
    assign vcnt_o = r_q.vcnt;
    assign vext_o = r_q.vext;
    assign tim2_o = r_q.tim2;
    assign subp_o = r_q.subp;
endmodule

// File: rtl/lcdr_evt.sv
module lcdr_evt
    import lcdr_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       en_i,
    input  logic [1:0] plm_i,
    input  logic [1:0] ie_i,
    input  logic       ev_frame_i,
    input  logic       ev_pal_i,
    input  logic       ev_sync_i,
    output flags_t     flags_o,
    output logic       start_o,
    output logic       stop_o,
    output logic       irq_o
);
    typedef struct packed {
        logic   en_prev;
        flags_t flags;
        logic   irq;
    } evst_t;

    evst_t s_d, s_q;

    assign start_o = en_i && !s_q.en_prev;
    assign stop_o  = !en_i && s_q.en_prev;

    always_comb begin
        s_d         = s_q;
        s_d.en_prev = en_i;
        if (ev_frame_i) s_d.flags.frame = 1'b1;
        if (ev_pal_i)   s_d.flags.pal   = 1'b1;
        if (ev_sync_i)  s_d.flags.sync  = 1'b1;
        if (start_o) begin
            s_d.flags.frame = 1'b0;
            s_d.flags.pal   = 1'b0;
        end
        if (stop_o) begin
            s_d.flags.sync = 1'b0;
            if (plm_i != 2'd1) s_d.flags.frame = 1'b1;
        end
        s_d.irq = (s_q.flags.frame && ie_i[0])
               || (s_q.flags.pal && ie_i[1])
               || s_q.flags.sync;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign flags_o = s_q.flags;
    assign irq_o   = s_q.irq;
endmodule

// File: rtl/lcdr_top.sv
module lcdr_top
    import lcdr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 10
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               bus_sel_i,
    input  logic               bus_we_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [31:0]        bus_wdata_i,
    output logic [31:0]        bus_rdata_o,
    input  logic               ev_frame_i,
    input  logic               ev_pal_i,
    input  logic               ev_sync_i,
    output logic               fetch_start_o,
    output logic               fetch_stop_o,
    output logic               irq_o,
    output logic               mono_o,
    output logic               tft_o,
    output logic [1:0]         plm_o,
    output logic [CNT_W-1:0]   pix_per_line_o,
    output logic [31-CNT_W:0]  hor_ext_o,
    output logic [CNT_W-1:0]   lines_o,
    output logic [31-CNT_W:0]  ver_ext_o,
    output logic [31:0]        tim2_o,
    output logic [31:0]        subpanel_o
);
    ctrl_t  ctrl;
    flags_t flags;
    logic   frame_flag, pal_flag, sync_flag;

    lcdr_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .sel_i   (bus_sel_i),
        .we_i    (bus_we_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .flags_i (flags),
        .rdata_o (bus_rdata_o),
        .ctrl_o  (ctrl),
        .hcnt_o  (pix_per_line_o),
        .hext_o  (hor_ext_o),
        .vcnt_o  (lines_o),
        .vext_o  (ver_ext_o),
        .tim2_o  (tim2_o),
        .subp_o  (subpanel_o)
    );

    lcdr_evt u_evt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (ctrl.en),
        .plm_i      (ctrl.plm),
        .ie_i       (ctrl.ie),
        .ev_frame_i (ev_frame_i),
        .ev_pal_i   (ev_pal_i),
        .ev_sync_i  (ev_sync_i),
        .flags_o    (flags),
        .start_o    (fetch_start_o),
        .stop_o     (fetch_stop_o),
        .irq_o      (irq_o)
    );

    assign frame_flag = flags.frame;
    assign pal_flag   = flags.pal;
    assign sync_flag  = flags.sync;
    assign mono_o     = ctrl.mono;
    assign tft_o      = ctrl.tft;
    assign plm_o      = ctrl.plm;
endmodule

// File: rtl/lcdr_chk.sv
module lcdr_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       start,
    input logic       stop,
    input logic       irq,
    input logic       frame,
    input logic       pal,
    input logic       sync,
    input logic       ev_sync,
    input logic [1:0] plm
);
    AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start |=> !start);                                   // R9
    AST_STOP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop |=> !stop);                                     // R10
    AST_EDGES_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(start && stop));                                   // R9
    AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start |=> (!frame && !pal));                         // R12
    AST_STOP_CLEARS_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop |=> !sync);                                     // R10
    AST_STOP_SETS_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stop && plm != 2'd1) |=> frame);                    // R10
    AST_SYNC_RAISES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sync |=> irq);                                       // R8
    AST_IDLE_IRQ_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!frame && !pal && !sync) |=> !irq);                 // R8
    AST_SYNC_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sync && !stop) |=> sync);                           // R7
    AST_SYNC_EVENT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ev_sync && !stop) |=> sync);                        // R7
endmodule

bind lcdr_top lcdr_chk u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start   (fetch_start_o),
    .stop    (fetch_stop_o),
    .irq     (irq_o),
    .frame   (frame_flag),
    .pal     (pal_flag),
    .sync    (sync_flag),
    .ev_sync (ev_sync_i),
    .plm     (plm_o)
);

// File: tb/tb_lcdr_top.sv
module tb_lcdr_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ev_f = 1'b0, ev_p = 1'b0, ev_s = 1'b0;
    logic        start, stop, irq, mono, tft;
    logic [1:0]  plm;
    logic [9:0]  hpix, vlin;
    logic [21:0] hext, vext;
    logic [31:0] tim2, subp;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    lcdr_top dut (
        .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .ev_frame_i(ev_f), .ev_pal_i(ev_p), .ev_sync_i(ev_s),
        .fetch_start_o(start), .fetch_stop_o(stop), .irq_o(irq),
        .mono_o(mono), .tft_o(tft), .plm_o(plm),
        .pix_per_line_o(hpix), .hor_ext_o(hext), .lines_o(vlin),
        .ver_ext_o(vext), .tim2_o(tim2), .subpanel_o(subp)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk); sel = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); sel = 1'b1; we = 1'b0; addr = a;
        #1 chk(rdata == exp, tag, rdata, exp);
        sel = 1'b0;
    endtask

    task automatic tick(); @(negedge clk); endtask

    task automatic t_reset();
        rd(8'h00, 32'hFE00_0C34, "R1 ctrl");
        rd(8'h04, 32'h0000_000F, "R1 tim0");
        rd(8'h08, 32'h0, "R1 tim1");
        rd(8'h0C, 32'hFC00_0000, "R1 tim2");
        rd(8'h10, 32'h0, "R1 status");
        rd(8'h14, 32'h0, "R1 subpanel");
        chk({irq, start, stop} == 3'b000, "R1 outputs", {irq, start, stop}, 0);
    endtask

    task automatic t_ctrl();
        wr(8'h00, 32'hFFFF_FFFE);
        chk(start == 1'b0, "R2 no start with en=0", start, 0);
        rd(8'h00, 32'hFFFF_FFBE, "R2 ctrl all ones");
        chk({mono, tft, plm} == 4'b1111, "R2 mode outputs", {mono, tft, plm}, 4'hF);
        wr(8'h00, 32'h0000_0080);
        rd(8'h00, 32'hFE80_0CB4, "R2 tft echo bit 23");
        wr(8'h00, 32'h0);
        rd(8'h00, 32'hFE00_0C34, "R2 ctrl cleared");
    endtask

    task automatic t_timing();
        wr(8'h04, 32'h1234_5678);
        rd(8'h04, 32'h1234_567F, "R3 tim0 read");
        chk(hpix == 10'h278, "R3 pixels field", 32'(hpix), 32'h278);
        chk(hext == 22'h48D15, "R3 tim0 upper", 32'(hext), 32'h48D15);
        wr(8'h08, 32'hABCD_E3FF);
        rd(8'h08, 32'hABCD_E3FF, "R3 tim1 read");
        chk(vlin == 10'h3FF && vext == 22'h2AF378, "R3 lines field", {vext, vlin}, 32'hABCD_E3FF);
        wr(8'h0C, 32'h0000_1234);
        rd(8'h0C, 32'hFC00_1234, "R4 tim2 read");
        chk(tim2 == 32'h1234, "R4 tim2 output", tim2, 32'h1234);
    endtask

    task automatic t_subp();
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h14, 32'hA1FF_FFFF, "R5 subpanel mask");
        chk(subp == 32'hA1FF_FFFF, "R5 subpanel output", subp, 32'hA1FF_FFFF);
    endtask

    task automatic t_ignore();
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, 32'h0, "R6 status write ignored");
        chk({start, stop} == 2'b00, "R6 no pulse", {start, stop}, 0);
        wr(8'h18, 32'h5555_5555);
        rd(8'h18, 32'h0, "R6 unmapped 0x18 reads zero");
        wr(8'hFC, 32'h5555_5555);
        wr(8'h0D, 32'h5555_5555);
        rd(8'h0D, 32'h0, "R6 misaligned reads zero");
        rd(8'h0C, 32'hFC00_1234, "R6 tim2 untouched");
        rd(8'h14, 32'hA1FF_FFFF, "R6 subpanel untouched");
        rd(8'h00, 32'hFE00_0C34, "R6 ctrl untouched");
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which) 0: ev_f = 1'b1; 1: ev_p = 1'b1; default: ev_s = 1'b1; endcase
        @(negedge clk); ev_f = 1'b0; ev_p = 1'b0; ev_s = 1'b0;
    endtask

    task automatic t_events();
        pulse(1);
        rd(8'h10, 32'h40, "R7 palette flag");
        chk(irq == 1'b0, "R8 palette masked", irq, 0);
        wr(8'h00, 32'h10);
        tick();
        chk(irq == 1'b1, "R8 palette enabled irq", irq, 1);
        pulse(0);
        rd(8'h10, 32'h41, "R7 frame flag, sticky palette");
        wr(8'h00, 32'h0);
        tick();
        chk(irq == 1'b0, "R8 irq low with enables off", irq, 0);
        wr(8'h00, 32'h08);
        tick();
        chk(irq == 1'b1, "R8 frame enabled irq", irq, 1);
        wr(8'h00, 32'h0);
        pulse(2);
        rd(8'h10, 32'h45, "R7 sync flag");
        chk(irq == 1'b1, "R8 sync ignores enables", irq, 1);
    endtask

    task automatic t_enable();
        wr(8'h00, 32'h1);
        chk(start == 1'b1 && stop == 1'b0, "R9 start pulse", {start, stop}, 2'b10);
        tick();
        chk(start == 1'b0, "R9 start one cycle", start, 0);
        rd(8'h10, 32'h04, "R9 frame and palette cleared");
        chk(irq == 1'b1, "R8 irq from sync", irq, 1);
        wr(8'h00, 32'h0);
        chk(stop == 1'b1 && start == 1'b0, "R10 stop pulse", {start, stop}, 2'b01);
        tick();
        chk(stop == 1'b0, "R10 stop one cycle", stop, 0);
        rd(8'h10, 32'h01, "R10 frame set, sync cleared");
        chk(irq == 1'b0, "R8 irq drops", irq, 0);
        wr(8'h00, 32'h0);
        chk({start, stop} == 2'b00, "R11 same enable no pulse", {start, stop}, 0);
        tick();
        rd(8'h10, 32'h01, "R11 flags unchanged");
        wr(8'h00, 32'h1);
        tick();
        pulse(2);
        wr(8'h00, 32'h0010_0000);
        tick();
        rd(8'h10, 32'h00, "R10 palette mode 1 leaves frame clear");
    endtask

    task automatic t_priority();
        pulse(0);
        wr(8'h00, 32'h1);
        ev_p = 1'b1; ev_f = 1'b1;
        @(negedge clk); ev_p = 1'b0; ev_f = 1'b0;
        rd(8'h10, 32'h00, "R12 start beats events");
        pulse(1);
        rd(8'h10, 32'h40, "R7 palette after start");
        wr(8'h00, 32'h0);
        ev_s = 1'b1;
        @(negedge clk); ev_s = 1'b0;
        rd(8'h10, 32'h41, "R12 stop beats sync event");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl();
        t_timing();
        t_subp();
        t_ignore();
        t_events();
        t_enable();
        t_priority();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule